// File: doc/BRIEF.md
# NCO Phase Generator with Dither

This block is the phase front end of a numerically controlled oscillator. A two's-complement accumulator gains one phase step on every cycle in which the valid input is high. It keeps its value when the valid input is low. A clear input returns it to zero. The accumulator wraps on overflow and never saturates. The step comes either from an input port or from a fixed parameter.

A second register stage adds a phase offset and a small unsigned dither word to the current phase. It then keeps only the top bits of the sum, a floor quantization, to form the address of a downstream sine table. The dither word comes from one of three sources chosen by parameter:

- an internal LFSR that advances only on valid cycles,
- an input port,
- none, in which case the dither is zero.

An output valid flag is delayed so that it lines up with the quantized address.

Top module: `nco_phase_front`

## Requirements
- R1: While rst_ni is low, phase_o, quant_o and vld_o are all zero.
- R2: When vld_i is high and clr_i is low at a clock edge, phase_o after that edge equals the previous phase_o plus the step, modulo 2^ACC_W.
- R3: When vld_i and clr_i are both low, phase_o keeps its value.
- R4: When clr_i is high, phase_o becomes zero after the edge, whatever vld_i and the step are.
- R5: The accumulator wraps in two's complement. With ACC_W=16, 0x7FFF plus 1 gives 0x8000, and 0x8000 plus 0x8000 gives 0x0000.
- R6: quant_o equals bits [ACC_W-1 : ACC_W-QUANT_W] of (phase + offset + dither) mod 2^ACC_W. Here phase is the phase_o value of the previous cycle, and offset and dither are the values present during the same cycle. An offset of 0xFFFF on phase 0 gives 0xFFF.
- R7: vld_o equals vld_i delayed by exactly two clock cycles.
- R8: In port-dither mode, dith_i is zero-extended and added as an unsigned value. A dither that carries into bit ACC_W-QUANT_W raises quant_o by one: phase 0x0FF8 with dither 8 gives 0x100, and with dither 7 gives 0x0FF.
- R9: In LFSR-dither mode, the dither lies in 0..2^DITHER_W-1, so quant_o exceeds the undithered quantization by 0 or 1. The dither varies over time. It holds, and quant_o therefore holds, while vld_i is low.
- R10: In no-dither mode, quant_o is the undithered quantization of phase plus offset.
- R11: With INC_FROM_PORT=0, the step is INC_VALUE (default 100) and inc_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the phase accumulator |
| vld_i | input | 1 | Advance enable for accumulator and LFSR |
| inc_i | input | ACC_W | Phase step (port mode) |
| ofs_i | input | ACC_W | Phase offset |
| dith_i | input | DITHER_W | External dither word (port-dither mode) |
| quant_o | output | QUANT_W | Quantized dithered phase, table address |
| phase_o | output | ACC_W | Current accumulator value |
| vld_o | output | 1 | Valid flag aligned with quant_o |

## Verification
A corrupted accumulator shows on phase_o one cycle after the faulty edge. It stays wrong for good, because every later step builds on it. The same fault reaches quant_o one cycle later. A wrong dither source or an LFSR stepping while idle shows as a quant_o that moves during a hold. It can also show as a quant_o more than one code above the floor of phase plus offset. A misaligned valid pipe shows as vld_o rising one cycle too early or too late after an isolated vld_i pulse.

// File: rtl/nco_phase_pkg.sv
package nco_phase_pkg;
  typedef enum logic [1:0] {
    DITH_NONE = 2'd0,
    DITH_LFSR = 2'd1,
    DITH_PORT = 2'd2
  } dith_src_e;

  localparam int unsigned VLD_LAT = 2;
endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  // clear wins over advance; addition wraps naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (adv_i) acc_q <= acc_q + inc_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/nco_dither_src.sv
module nco_dither_src
  import nco_phase_pkg::*;
#(
  parameter dith_src_e          SRC       = DITH_LFSR,
  parameter int unsigned        DITHER_W  = 4,
  parameter int unsigned        LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  LFSR_POLY = 16'hB400,
  parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic [DITHER_W-1:0] ext_i,
  output logic [DITHER_W-1:0] dith_o
);
  if (SRC == DITH_LFSR) begin : g_lfsr
    logic [LFSR_W-1:0] lfsr_q, lfsr_d;
    logic              unused_ext;

    // Galois form, right shift
    always_comb begin
      lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
      if (lfsr_q[0]) lfsr_d = lfsr_d ^ LFSR_POLY;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lfsr_q <= LFSR_SEED;
      else if (adv_i) lfsr_q <= lfsr_d;
    end

    assign dith_o     = lfsr_q[DITHER_W-1:0];
    assign unused_ext = ^ext_i;
  end else if (SRC == DITH_PORT) begin : g_port
    logic unused_ctl;
    assign dith_o     = ext_i;
    assign unused_ctl = ^{clk_i, rst_ni, adv_i};
  end else begin : g_none
    logic unused_ctl;
    assign dith_o     = '0;
    assign unused_ctl = ^{clk_i, rst_ni, adv_i, ext_i};
  end
endmodule

// File: rtl/nco_phase_quant.sv
module nco_phase_quant #(
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned QUANT_W  = 12,
  parameter int unsigned DITHER_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ACC_W-1:0]    acc_i,
  input  logic [ACC_W-1:0]    ofs_i,
  input  logic [DITHER_W-1:0] dith_i,
  output logic [QUANT_W-1:0]  quant_o
);
  localparam int unsigned DROP_W = ACC_W - QUANT_W;

  logic [ACC_W-1:0]   sum;
  logic [QUANT_W-1:0] quant_q;
  logic [DROP_W-1:0]  unused_lsb;

  assign sum        = acc_i + ofs_i + {{(ACC_W-DITHER_W){1'b0}}, dith_i};
  assign unused_lsb = sum[DROP_W-1:0];

  // floor quantization: keep MSBs only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) quant_q <= '0;
    else         quant_q <= sum[ACC_W-1:DROP_W];
  end

  assign quant_o = quant_q;
endmodule

// File: rtl/nco_phase_front.sv
module nco_phase_front
  import nco_phase_pkg::*;
#(
  parameter int unsigned       ACC_W         = 16,
  parameter int unsigned       QUANT_W       = 12,
  parameter int unsigned       DITHER_W      = 4,
  parameter dith_src_e         DITH_SRC      = DITH_LFSR,
  parameter bit                INC_FROM_PORT = 1'b1,
  parameter int unsigned       INC_VALUE     = 100,
  parameter int unsigned       LFSR_W        = 16,
  parameter logic [LFSR_W-1:0] LFSR_POLY     = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED     = 16'hACE1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                vld_i,
  input  logic [ACC_W-1:0]    inc_i,
  input  logic [ACC_W-1:0]    ofs_i,
  input  logic [DITHER_W-1:0] dith_i,
  output logic [QUANT_W-1:0]  quant_o,
  output logic [ACC_W-1:0]    phase_o,
  output logic                vld_o
);
  logic [ACC_W-1:0]    inc_eff;
  logic [DITHER_W-1:0] dith_w;
  logic [VLD_LAT-1:0]  vld_pipe_q;

  if (INC_FROM_PORT) begin : g_inc_port
    assign inc_eff = inc_i;
  end else begin : g_inc_fixed
    logic unused_inc;
    assign inc_eff    = ACC_W'(INC_VALUE);
    assign unused_inc = ^inc_i;
  end

  nco_phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .adv_i (vld_i),
    .inc_i (inc_eff),
    .acc_o (phase_o)
  );

  nco_dither_src #(
    .SRC      (DITH_SRC),
    .DITHER_W (DITHER_W),
    .LFSR_W   (LFSR_W),
    .LFSR_POLY(LFSR_POLY),
    .LFSR_SEED(LFSR_SEED)
  ) u_dither (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (vld_i),
    .ext_i (dith_i),
    .dith_o(dith_w)
  );

  nco_phase_quant #(
    .ACC_W   (ACC_W),
    .QUANT_W (QUANT_W),
    .DITHER_W(DITHER_W)
  ) u_quant (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (phase_o),
    .ofs_i  (ofs_i),
    .dith_i (dith_w),
    .quant_o(quant_o)
  );

  // one stage for the accumulator, one for the quantizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_pipe_q <= '0;
    else         vld_pipe_q <= {vld_pipe_q[VLD_LAT-2:0], vld_i};
  end

  assign vld_o = vld_pipe_q[VLD_LAT-1];
endmodule

// File: rtl/nco_phase_front_chk.sv
module nco_phase_front_chk #(
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned DITHER_W = 4,
  parameter bit          IS_LFSR  = 1'b0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                vld_i,
  input logic [ACC_W-1:0]    inc_eff_i,
  input logic [DITHER_W-1:0] dith_i,
  input logic [ACC_W-1:0]    phase_i,
  input logic                vld_o_i
);
  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (phase_i == '0 && !vld_o_i));

  // R2
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i) |=> phase_i == ACC_W'($past(phase_i) + $past(inc_eff_i)));

  // R3
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(phase_i));

  // R4
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_i == '0);

  // R7
  vld_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> ##2 vld_o_i);

  // R7
  vld_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |-> ##2 !vld_o_i);

  // R9
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_LFSR && !vld_i) |=> $stable(dith_i));
endmodule

bind nco_phase_front nco_phase_front_chk #(
  .ACC_W   (ACC_W),
  .DITHER_W(DITHER_W),
  .IS_LFSR (DITH_SRC == nco_phase_pkg::DITH_LFSR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .vld_i    (vld_i),
  .inc_eff_i(inc_eff),
  .dith_i   (dith_w),
  .phase_i  (phase_o),
  .vld_o_i  (vld_o)
);

// File: tb/sim_nco_phase_front.sv
module sim_nco_phase_front;
  import nco_phase_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr = 1'b0, vld = 1'b0;
  logic [15:0] inc = '0, ofs = '0;
  logic [3:0]  dith = '0;

  logic [11:0] q0, q1, q2;
  logic [15:0] p0, p1, p2;
  logic        v0, v1, v2;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m0 = '0, m2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_phase_front #(.DITH_SRC(DITH_PORT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .vld_i(vld), .inc_i(inc),
    .ofs_i(ofs), .dith_i(dith), .quant_o(q0), .phase_o(p0), .vld_o(v0));

  nco_phase_front #(.DITH_SRC(DITH_LFSR)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .vld_i(vld), .inc_i(inc),
    .ofs_i(ofs), .dith_i(dith), .quant_o(q1), .phase_o(p1), .vld_o(v1));

  nco_phase_front #(.DITH_SRC(DITH_NONE), .INC_FROM_PORT(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .vld_i(vld), .inc_i(inc),
    .ofs_i(ofs), .dith_i(dith), .quant_o(q2), .phase_o(p2), .vld_o(v2));

  function automatic logic [11:0] expq(logic [15:0] a, logic [15:0] o, logic [3:0] d);
    logic [15:0] s;
    s = a + o + {12'd0, d};
    return s[15:4];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock; models follow the inputs present during the cycle
  task automatic tick();
    logic c, v;
    logic [15:0] i;
    c = clr; v = vld; i = inc;
    @(posedge clk);
    #1;
    if (c) begin m0 = '0; m2 = '0; end
    else if (v) begin m0 = m0 + i; m2 = m2 + 16'd100; end
  endtask

  task automatic t_reset();
    chk("R1 phase", p0, 0);
    chk("R1 quant", q0, 0);
    chk("R1 vld", v0, 0);
  endtask

  task automatic t_step();
    clr = 1'b1; vld = 1'b0; tick();
    chk("R4 clr", p0, 0);
    clr = 1'b0; vld = 1'b1; inc = 16'd100;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2 step", p0, m0);
      chk("R11 fixed step", p2, m2);
      chk("R7 vld rise", v0, (i == 0) ? 0 : 1);
    end
    inc = 16'h1111; tick();
    chk("R11 inc_i ignored", p2, 16'd500);
  endtask

  task automatic t_hold();
    logic [15:0] held;
    vld = 1'b0; held = p0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R3 hold", p0, held);
      chk("R7 vld fall", v0, (i == 0) ? 1 : 0);
    end
  endtask

  task automatic t_clear();
    vld = 1'b1; clr = 1'b1; inc = 16'd55; tick();
    chk("R4 clr with vld", p0, 0);
    chk("R4 clr fixed", p2, 0);
    clr = 1'b0; vld = 1'b0;
  endtask

  task automatic t_wrap();
    clr = 1'b1; tick(); clr = 1'b0; vld = 1'b1;
    inc = 16'h7FFF; tick(); chk("R5 max", p0, 16'h7FFF);
    inc = 16'h0001; tick(); chk("R5 to neg", p0, 16'h8000);
    inc = 16'h8000; tick(); chk("R5 to zero", p0, 16'h0000);
    vld = 1'b0;
  endtask

  task automatic load(logic [15:0] val);
    clr = 1'b1; vld = 1'b0; tick();
    clr = 1'b0; vld = 1'b1; inc = val; tick();
    vld = 1'b0;
  endtask

  task automatic quant_case(string req, logic [15:0] a, logic [15:0] o,
                            logic [3:0] d, logic [11:0] exp);
    load(a);
    ofs = o; dith = d;
    tick(); tick();
    chk(req, q0, exp);
    chk("R10 no dither", q2, expq(m2, o, 4'd0));
  endtask

  task automatic t_quant();
    quant_case("R6 sum", 16'h1234, 16'h0F00, 4'hF, 12'h214);
    quant_case("R8 carry", 16'h0FF8, 16'h0000, 4'h8, 12'h100);
    quant_case("R8 no carry", 16'h0FF8, 16'h0000, 4'h7, 12'h0FF);
    quant_case("R6 neg offset", 16'h0000, 16'hFFFF, 4'h0, 12'hFFF);
    ofs = '0; dith = '0;
  endtask

  task automatic t_lfsr();
    logic [15:0] prev;
    logic [11:0] diff, held;
    int ones = 0, zeros = 0;
    clr = 1'b1; tick(); clr = 1'b0;
    ofs = '0; inc = 16'h0123; vld = 1'b1;
    prev = p1;
    for (int i = 0; i < 40; i++) begin
      tick();
      diff = q1 - expq(prev, 16'h0, 4'd0);
      if (diff == 12'd1) ones++;
      if (diff == 12'd0) zeros++;
      chk("R9 dither range", (diff <= 12'd1), 1);
      prev = p1;
    end
    chk("R9 dither varies", (ones > 0 && zeros > 0), 1);
    vld = 1'b0; tick(); tick();
    held = q1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9 idle hold", q1, held);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_step();
    t_hold();
    t_clear();
    t_wrap();
    t_quant();
    t_lfsr();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule